// File: doc/BRIEF.md
# Associative Word Store with Miss Flag

This block holds a small array of words that can be reached in two ways. By address it acts like any synchronous RAM: a write port stores a word, and a read port returns the word at a given address one cycle later. By content it acts as a lookup table: a search port takes a key, compares it with every stored word in the same cycle, and produces one match bit per word together with a single miss flag.

Each word carries a valid bit that is clear after reset and set by the first write to that word. Words that were never written take no part in a search. Search results are registered. They appear on the cycle after the search strobe, marked by a one-cycle result-valid pulse, and they hold their values until the next search completes. A write issued in the same cycle as a search lands in the array, but the search sees the contents from before that write. A read and a search in the same cycle is a protocol error. In that case the search goes ahead and the read is dropped, so the read data keeps its old value.

Top module: `assoc_mem`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. A read with `rd_en` high puts the word at `rd_addr` on `rd_data` at the next clock edge, and `rd_data` holds that value until the next accepted read.
- R2: After reset, `rd_data`, `hit_vec`, `miss` and `res_vld` are all zero, every word holds zero, and every word is invalid.
- R3: `res_vld` is high for exactly the cycle after each cycle in which `srch_en` is high, and low at all other times.
- R4: In a result cycle, bit i of `hit_vec` is 1 exactly when word i is valid and equal to the key. Any number of bits may be set at the same time.
- R5: In a result cycle, `miss` is 1 exactly when no bit of `hit_vec` is set.
- R6: A word that has not been written since reset never sets its `hit_vec` bit, even when the key equals its zero contents.
- R7: When a write and a search occur in the same cycle, the search result reflects the array as it was before the write. The write takes effect for all later reads and searches.
- R8: When `rd_en` and `srch_en` are high in the same cycle, the search completes normally and `rd_data` keeps its previous value.
- R9: A search changes no stored word and no valid bit. Reading the array back after any number of searches returns the written data.
- R10: In cycles that are not result cycles, `hit_vec` and `miss` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word index to write |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Word index to read |
| rd_data | output | WIDTH | Registered read word |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Key compared against all words |
| hit_vec | output | DEPTH | Registered per-word match bits |
| miss | output | 1 | Registered flag: no word matched |
| res_vld | output | 1 | One-cycle pulse marking a fresh search result |

## Verification
In a four-word, four-bit setup, every key value is searched against several array fills:
- Distinct words, where each key should hit exactly one index or miss.
- All words equal, where the result should be all-hit or all-miss.
- Two different scrambled fills, which catch errors in bit positions and indices.

A search right after reset with key zero checks the valid-bit gating (R6), because an ungated comparator would match the zero contents. Three further tests check the same-cycle cases:
- A write and a search in one cycle, followed by a second search, shows whether the search saw the old or the new word.
- A read and a search in one cycle shows whether the read was dropped.
- Idle cycles after a search show whether the registered results hold their values.

// File: rtl/assoc_mem_pkg.sv
package assoc_mem_pkg;

   // Index width for a word count, never below one bit.
   function automatic int am_index_w(input int depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   function automatic bit am_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/assoc_mem_store.sv
// Word array with per-word valid bits and a registered read port.
module assoc_mem_store #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   parameter int AW    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_addr,
   input  logic [WIDTH-1:0]             wr_data,
   input  logic                         rd_en,
   input  logic                         rd_block,
   input  logic [AW-1:0]                rd_addr,
   output logic [WIDTH-1:0]             rd_data,
   output logic [DEPTH-1:0][WIDTH-1:0]  words,
   output logic [DEPTH-1:0]             valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
         valid <= '0;
      end else if (wr_en) begin
         words[wr_addr] <= wr_data;
         valid[wr_addr] <= 1'b1;
      end
   end

   // A read that coincides with a search is dropped; the old data stays.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en && !rd_block)
         rd_data <= words[rd_addr];
   end

endmodule

// File: rtl/assoc_mem_cmp.sv
// One equality comparator per word, gated by that word's valid bit.
module assoc_mem_cmp #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] words,
   input  logic [DEPTH-1:0]            valid,
   input  logic [WIDTH-1:0]            key,
   output logic [DEPTH-1:0]            match
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_line
      assign match[i] = valid[i] && (words[i] == key);
   end

endmodule

// File: rtl/assoc_mem_result.sv
// Registers the match lines, the miss flag and the result pulse.
module assoc_mem_result #(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srch_en,
   input  logic [DEPTH-1:0] match,
   output logic [DEPTH-1:0] hit_vec,
   output logic             miss,
   output logic             res_vld
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vec <= '0;
         miss    <= 1'b0;
         res_vld <= 1'b0;
      end else begin
         res_vld <= srch_en;
         if (srch_en) begin
            hit_vec <= match;
            miss    <= ~|match;
         end
      end
   end

endmodule

// File: rtl/assoc_mem.sv
// Associative word store: addressed read/write plus parallel key search.
module assoc_mem
   import assoc_mem_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   localparam int AW   = am_index_w(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             srch_en,
   input  logic [WIDTH-1:0] srch_key,
   output logic [DEPTH-1:0] hit_vec,
   output logic             miss,
   output logic             res_vld
);

   if (!am_is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("assoc_mem: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("assoc_mem: WIDTH must be at least 1");
   end

   logic [DEPTH-1:0][WIDTH-1:0] words;
   logic [DEPTH-1:0]            valid;
   logic [DEPTH-1:0]            match;

   assoc_mem_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_block (srch_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .words    (words),
      .valid    (valid)
   );

   // The comparators see the register outputs, so a write in the same
   // cycle is not yet visible to the search.
   assoc_mem_cmp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cmp_i (
      .words (words),
      .valid (valid),
      .key   (srch_key),
      .match (match)
   );

   assoc_mem_result #(.DEPTH(DEPTH)) res_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .srch_en (srch_en),
      .match   (match),
      .hit_vec (hit_vec),
      .miss    (miss),
      .res_vld (res_vld)
   );

endmodule

// File: rtl/assoc_mem_chk.sv
module assoc_mem_chk #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   parameter int AW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic             rd_en,
   input logic             srch_en,
   input logic [WIDTH-1:0] rd_data,
   input logic [DEPTH-1:0] hit_vec,
   input logic             miss,
   input logic             res_vld
);

   // Words written since reset, tracked from the port activity.
   logic [DEPTH-1:0] seen;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= '0;
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (wr_en) seen[wr_addr] <= 1'b1;
      end
   end

   // R3
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      srch_en |=> res_vld);

   // R3
   res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !srch_en |=> !res_vld);

   // R5
   miss_nor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (miss == (hit_vec == '0)));

   // R6
   unwritten_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      srch_en |=> ((hit_vec & ~$past(seen)) == '0));

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (rd_en && srch_en) |=> $stable(rd_data));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !srch_en |=> ($stable(hit_vec) && $stable(miss)));

endmodule

bind assoc_mem assoc_mem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .rd_en   (rd_en),
   .srch_en (srch_en),
   .rd_data (rd_data),
   .hit_vec (hit_vec),
   .miss    (miss),
   .res_vld (res_vld)
);

// File: tb/assoc_mem_tb_top.sv
module assoc_mem_tb_top;

   localparam int DEPTH = 4;
   localparam int WIDTH = 4;
   localparam int AW    = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_addr = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             rd_en = 1'b0;
   logic [AW-1:0]    rd_addr = '0;
   logic [WIDTH-1:0] rd_data;
   logic             srch_en = 1'b0;
   logic [WIDTH-1:0] srch_key = '0;
   logic [DEPTH-1:0] hit_vec;
   logic             miss;
   logic             res_vld;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [WIDTH-1:0] model [DEPTH];
   logic [DEPTH-1:0] mvalid = '0;

   always #5 clk = ~clk;

   assoc_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .srch_en  (srch_en),
      .srch_key (srch_key),
      .hit_vec  (hit_vec),
      .miss     (miss),
      .res_vld  (res_vld)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DEPTH-1:0] exp_hits(input logic [WIDTH-1:0] key);
      logic [DEPTH-1:0] h = '0;
      for (int i = 0; i < DEPTH; i++)
         h[i] = mvalid[i] && (model[i] == key);
      return h;
   endfunction

   task automatic do_write(input int a, input logic [WIDTH-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[a] = d;
      mvalid[a] = 1'b1;
   endtask

   task automatic do_read(input int a, input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rd_data, model[a]);
   endtask

   task automatic do_search(input logic [WIDTH-1:0] key, input string req);
      logic [DEPTH-1:0] e;
      e = exp_hits(key);
      @(negedge clk);
      srch_en = 1'b1; srch_key = key;
      @(negedge clk);
      srch_en = 1'b0;
      chk({req, " res_vld R3"}, res_vld, 1);
      chk({req, " hit_vec R4"}, hit_vec, e);
      chk({req, " miss R5"}, miss, (e == '0));
   endtask

   function automatic logic [WIDTH-1:0] fill(input int p, input int i);
      case (p)
         0:       return WIDTH'(i);
         1:       return WIDTH'(9);
         2:       return WIDTH'(15 - 5 * i);
         default: return WIDTH'(i * 7 + 3);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [WIDTH-1:0] last_rd;
      logic [DEPTH-1:0] h_old;
      logic             m_old;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;

      repeat (3) @(negedge clk);
      // R2: reset state at the outputs
      chk("R2 rd_data", rd_data, 0);
      chk("R2 hit_vec", hit_vec, 0);
      chk("R2 miss", miss, 0);
      chk("R2 res_vld", res_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 no result without search", res_vld, 0);

      // R6: key zero on zero-content, unwritten words must miss
      do_search('0, "R6 search after reset");
      chk("R6 no hit on unwritten", hit_vec, 0);
      do_read(2, "R2 reset contents");

      // R6: one written word, the others stay unmatched
      do_write(1, '0);
      do_search('0, "R6 single written zero");

      // R1, R4, R5: several fills, every key searched
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < DEPTH; i++) do_write(i, fill(p, i));
         for (int i = 0; i < DEPTH; i++) do_read(i, "R1 read back");
         for (int k = 0; k < (1 << WIDTH); k++) do_search(WIDTH'(k), "R4 sweep");
         // R9: the searches left the contents alone
         for (int i = 0; i < DEPTH; i++) do_read(i, "R9 intact after searches");
      end

      // R4: two words equal, multi-hit
      do_write(0, 4'h5);
      do_write(2, 4'h5);
      do_search(4'h5, "R4 multi-hit");
      chk("R4 two bits set", $countones(hit_vec), 2);

      // R7: write and search in the same cycle
      begin
         logic [DEPTH-1:0] e;
         e = exp_hits(4'hC);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'hC;
         srch_en = 1'b1; srch_key = 4'hC;
         @(negedge clk);
         wr_en = 1'b0; srch_en = 1'b0;
         chk("R7 search saw old contents", hit_vec, e);
         chk("R7 miss on old contents", miss, (e == '0));
         model[3] = 4'hC;
         mvalid[3] = 1'b1;
         do_search(4'hC, "R7 new word visible");
         chk("R7 word 3 now hits", hit_vec[3], 1);
         do_read(3, "R7 write landed");
      end

      // R8: read dropped when it collides with a search
      do_read(0, "R1 read before collision");
      last_rd = rd_data;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 2'd3;
      srch_en = 1'b1; srch_key = 4'h5;
      @(negedge clk);
      rd_en = 1'b0; srch_en = 1'b0;
      chk("R8 rd_data held", rd_data, last_rd);
      chk("R8 search still ran", res_vld, 1);
      chk("R8 search hits", hit_vec, exp_hits(4'h5));

      // R10: results hold across idle cycles
      h_old = hit_vec;
      m_old = miss;
      repeat (3) @(negedge clk);
      chk("R10 hit_vec held", hit_vec, h_old);
      chk("R10 miss held", miss, m_old);
      chk("R3 pulse ended", res_vld, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule